// File: doc/BRIEF.md
# Merged Priority Process State Selector

Several simultaneous processes have been folded into one core. They share a single adder, so on each clock only one of their states may be issued. Each process keeps an ordered list of states. Index 0 is its most urgent and least frequent state. The last index is its most frequent, lowest-urgency state. A state asks to run by raising its request bit, which happens when its stimulus is present: queue data, a feedback value, an input word or a loop-register condition.

The selector interleaves the processes rank by rank. Every process's index-0 state comes first, in ascending process number. Next come the index-1 states of the processes that have at least two states, and so on down the ranks. The highest requesting entry in this merged order wins. The block registers the winner once per clock and presents it as a process number, a state index and a valid flag. It also presents a one-hot grant for the shared adder.

The number of processes, the longest state list and the length of each process's list are parameters fixed at build time. The default build has four processes, with 7, 3, 4 and 6 states for processes 0 to 3.

Top module: `merged_state_sel`

## Requirements
- R1: While reset is asserted and after its release with no request seen, `sel_valid` is 0, `grant` is all zeros, and `sel_proc` and `sel_state` are 0.
- R2: The outputs reflect the `req` value sampled at the previous rising clock edge. A change of `req` between edges does not change the outputs before the next edge.
- R3: Request bit `p*MAX_STATES + s` belongs to state `s` of process `p`. A requesting state of lower index always wins over a requesting state of higher index, whatever the process numbers.
- R4: Among requesting states of equal index, the lowest process number wins.
- R5: Request bits whose state index is at or above the process's own state count are ignored. In the default build these are bits 10–13, 18–20 and 27.
- R6: When no counted state requests, `sel_valid` is 0, `grant` is all zeros, and `sel_proc` and `sel_state` are 0.
- R7: While `sel_valid` is 1, `grant` has exactly one bit set, at position `sel_proc`. The reported state always lies inside that process's list and was requesting one cycle earlier.
- R8: For any request vector, the reported winner equals the first requesting entry of the merged order. That order is sorted by state index, then by process number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NPROC*MAX_STATES | Request bits, process-major, state index within process |
| sel_valid | output | 1 | A state was selected |
| sel_proc | output | PW | Process number of the selected state |
| sel_state | output | SW | State index of the selected state within its process |
| grant | output | NPROC | One-hot shared-adder grant to the selected process |

## Verification
Every result is due one clock edge after the request vector it depends on, because the merge logic feeds a single register stage. The bench changes `req` on a falling edge and reads the outputs on the following falling edge, after exactly one rising edge has passed. To check the latency, it also reads the outputs just after driving a new vector, before any rising edge. At that point they must still show the previous selection. The random phase keeps to the same one-edge window and compares each result with a model that walks the merged order by state index, then by process number.

// File: rtl/merged_sel_pkg.sv
package merged_sel_pkg;
  localparam int CNT_W = 8;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/msel_mask.sv
module msel_mask #(
  parameter int NPROC      = 4,
  parameter int MAX_STATES = 7,
  parameter logic [NPROC*merged_sel_pkg::CNT_W-1:0] STATE_COUNTS = '0
) (
  input  logic [NPROC*MAX_STATES-1:0] req_in,
  output logic [NPROC*MAX_STATES-1:0] req_out
);
  import merged_sel_pkg::*;

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    for (genvar s = 0; s < MAX_STATES; s++) begin : g_state
      localparam bit InList = (s < int'(STATE_COUNTS[p*CNT_W +: CNT_W]));
      if (InList) begin : g_keep
        assign req_out[p*MAX_STATES+s] = req_in[p*MAX_STATES+s];
      end else begin : g_drop
        assign req_out[p*MAX_STATES+s] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/msel_rank_pick.sv
module msel_rank_pick #(
  parameter int NPROC = 4,
  parameter int PW    = 2
) (
  input  logic [NPROC-1:0] row,
  output logic             hit,
  output logic [PW-1:0]    pidx
);
  always_comb begin
    hit  = 1'b0;
    pidx = '0;
    for (int p = NPROC - 1; p >= 0; p--) begin
      if (row[p]) begin
        hit  = 1'b1;
        pidx = PW'(p);
      end
    end
  end
endmodule

// File: rtl/msel_out_reg.sv
module msel_out_reg #(
  parameter int NPROC = 4,
  parameter int PW    = 2,
  parameter int SW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_d,
  input  logic [PW-1:0]    proc_d,
  input  logic [SW-1:0]    state_d,
  output logic             sel_valid,
  output logic [PW-1:0]    sel_proc,
  output logic [SW-1:0]    sel_state,
  output logic [NPROC-1:0] grant
);
  logic             valid_nx;
  logic [PW-1:0]    proc_nx;
  logic [SW-1:0]    state_nx;
  logic [NPROC-1:0] grant_nx;

  always_comb begin
    valid_nx = any_d;
    proc_nx  = any_d ? proc_d  : '0;
    state_nx = any_d ? state_d : '0;
    grant_nx = any_d ? (NPROC'(1) << proc_d) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_proc  <= '0;
      sel_state <= '0;
      grant     <= '0;
    end else begin
      sel_valid <= valid_nx;
      sel_proc  <= proc_nx;
      sel_state <= state_nx;
      grant     <= grant_nx;
    end
  end
endmodule

// File: rtl/merged_state_sel.sv
module merged_state_sel #(
  parameter int NPROC      = 4,
  parameter int MAX_STATES = 7,
  parameter logic [NPROC*merged_sel_pkg::CNT_W-1:0] STATE_COUNTS =
    {8'd6, 8'd4, 8'd3, 8'd7},
  localparam int PW = merged_sel_pkg::width_of(NPROC),
  localparam int SW = merged_sel_pkg::width_of(MAX_STATES),
  localparam int RW = NPROC * MAX_STATES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RW-1:0]    req,
  output logic             sel_valid,
  output logic [PW-1:0]    sel_proc,
  output logic [SW-1:0]    sel_state,
  output logic [NPROC-1:0] grant
);
  logic [RW-1:0]         req_m;
  logic [MAX_STATES-1:0] rank_hit;
  logic [PW-1:0]         rank_pidx [MAX_STATES];
  logic                  any_d;
  logic [PW-1:0]         win_p;
  logic [SW-1:0]         win_s;

  msel_mask #(
    .NPROC(NPROC), .MAX_STATES(MAX_STATES), .STATE_COUNTS(STATE_COUNTS)
  ) u_mask (
    .req_in(req), .req_out(req_m)
  );

  for (genvar r = 0; r < MAX_STATES; r++) begin : g_rank
    logic [NPROC-1:0] row;
    for (genvar p = 0; p < NPROC; p++) begin : g_col
      assign row[p] = req_m[p*MAX_STATES + r];
    end
    msel_rank_pick #(.NPROC(NPROC), .PW(PW)) u_pick (
      .row(row), .hit(rank_hit[r]), .pidx(rank_pidx[r])
    );
  end

  always_comb begin
    any_d = 1'b0;
    win_p = '0;
    win_s = '0;
    for (int r = MAX_STATES - 1; r >= 0; r--) begin
      if (rank_hit[r]) begin
        any_d = 1'b1;
        win_p = rank_pidx[r];
        win_s = SW'(r);
      end
    end
  end

  msel_out_reg #(.NPROC(NPROC), .PW(PW), .SW(SW)) u_out (
    .clk(clk), .rst_n(rst_n), .any_d(any_d), .proc_d(win_p),
    .state_d(win_s), .sel_valid(sel_valid), .sel_proc(sel_proc),
    .sel_state(sel_state), .grant(grant)
  );
endmodule

// File: rtl/msel_chk.sv
module msel_chk #(
  parameter int NPROC      = 4,
  parameter int MAX_STATES = 7,
  parameter logic [NPROC*merged_sel_pkg::CNT_W-1:0] STATE_COUNTS = '0,
  parameter int PW = 2,
  parameter int SW = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NPROC*MAX_STATES-1:0] req,
  input logic                        sel_valid,
  input logic [PW-1:0]               sel_proc,
  input logic [SW-1:0]               sel_state,
  input logic [NPROC-1:0]            grant
);
  import merged_sel_pkg::*;

  logic [NPROC*MAX_STATES-1:0] req_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= '0;
    else        req_d <= req;
  end

  // R6
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (grant == '0 && sel_proc == '0 && sel_state == '0));

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (grant == (NPROC'(1) << sel_proc)));

  // R7
  grant_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == (sel_valid ? 1 : 0));

  // R5
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (int'(sel_state) < int'(STATE_COUNTS[sel_proc*CNT_W +: CNT_W])));

  // R2
  winner_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> req_d[int'(sel_proc)*MAX_STATES + int'(sel_state)]);

  // R2
  no_req_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_d == '0) |-> !sel_valid);
endmodule

bind merged_state_sel msel_chk #(
  .NPROC(NPROC), .MAX_STATES(MAX_STATES), .STATE_COUNTS(STATE_COUNTS),
  .PW(PW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .sel_valid(sel_valid),
  .sel_proc(sel_proc), .sel_state(sel_state), .grant(grant)
);

// File: tb/merged_state_sel_test.sv
module merged_state_sel_test;
  localparam int NP = 4;
  localparam int MS = 7;
  localparam int RW = NP * MS;
  localparam int CNT [NP] = '{7, 3, 4, 6};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [RW-1:0] req;
  logic          sel_valid;
  logic [1:0]    sel_proc;
  logic [2:0]    sel_state;
  logic [3:0]    grant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  merged_state_sel uut (
    .clk(clk), .rst_n(rst_n), .req(req), .sel_valid(sel_valid),
    .sel_proc(sel_proc), .sel_state(sel_state), .grant(grant)
  );

  function automatic logic [RW-1:0] bitof(input int p, input int s);
    return RW'(1) << (p*MS + s);
  endfunction

  // reference: walk by state index, then by process number
  task automatic model(input logic [RW-1:0] v, output bit ev,
                       output int ep, output int es);
    ev = 0; ep = 0; es = 0;
    for (int r = 0; r < MS && !ev; r++)
      for (int p = 0; p < NP && !ev; p++)
        if (r < CNT[p] && v[p*MS + r]) begin
          ev = 1; ep = p; es = r;
        end
  endtask

  task automatic compare(input string tag, input bit ev, input int ep,
                         input int es);
    logic [3:0] eg;
    eg = ev ? (4'd1 << ep) : 4'd0;
    checks++;
    if (sel_valid !== ev || int'(sel_proc) != ep || int'(sel_state) != es
        || grant !== eg) begin
      fails++;
      $display("FAIL %s: got v=%0b p=%0d s=%0d g=%b, expected v=%0b p=%0d s=%0d g=%b",
               tag, sel_valid, sel_proc, sel_state, grant, ev, ep, es, eg);
    end
  endtask

  task automatic apply(input logic [RW-1:0] v);
    @(negedge clk);
    req = v;
    @(negedge clk);
  endtask

  task automatic apply_check(input string tag, input logic [RW-1:0] v);
    bit ev; int ep, es;
    apply(v);
    model(v, ev, ep, es);
    compare(tag, ev, ep, es);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req = '1;
    #23;
    compare("R1 in reset", 0, 0, 0);
    req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release", 0, 0, 0);
  endtask

  task automatic t_idle;
    apply(bitof(2, 1));
    apply(RW'(0));
    compare("R6 idle", 0, 0, 0);
  endtask

  task automatic t_single;
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < CNT[p]; s++) begin
        apply(bitof(p, s));
        compare("R8 single", 1, p, s);
      end
  endtask

  task automatic t_rank;
    apply(bitof(0, 1) | bitof(3, 0));
    compare("R3 top of last beats rank1 of first", 1, 3, 0);
    apply(bitof(0, 6) | bitof(2, 3) | bitof(3, 5));
    compare("R3 lowest index wins", 1, 2, 3);
  endtask

  task automatic t_tie;
    apply(bitof(1, 2) | bitof(2, 2) | bitof(3, 2));
    compare("R4 tie at index 2", 1, 1, 2);
    apply(bitof(3, 0) | bitof(2, 0));
    compare("R4 tie at index 0", 1, 2, 0);
  endtask

  task automatic t_ignored;
    logic [RW-1:0] junk;
    junk = '0;
    for (int p = 0; p < NP; p++)
      for (int s = CNT[p]; s < MS; s++) junk |= bitof(p, s);
    apply(junk);
    compare("R5 out-of-list bits only", 0, 0, 0);
    apply(junk | bitof(0, 6));
    compare("R5 out-of-list beside legal", 1, 0, 6);
  endtask

  task automatic t_latency;
    apply(bitof(1, 0));
    @(negedge clk);
    req = bitof(3, 4);
    #1;
    compare("R2 no change before edge", 1, 1, 0);
    @(negedge clk);
    compare("R2 change after one edge", 1, 3, 4);
  endtask

  task automatic t_grant;
    apply(bitof(2, 3) | bitof(3, 3));
    checks++;
    if (grant !== 4'b0100 || sel_proc != 2'd2) begin
      fails++;
      $display("FAIL R7 grant: got g=%b p=%0d, expected g=0100 p=2", grant, sel_proc);
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 2000; i++) begin
      logic [RW-1:0] v;
      v = RW'($urandom);
      if (i % 3 == 0) v &= RW'($urandom);
      if (i % 3 == 1) v &= RW'($urandom) & RW'($urandom) & RW'($urandom);
      apply_check("R8 random", v);
    end
  endtask

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_rank();
    t_tie();
    t_ignored();
    t_latency();
    t_grant();
    t_random();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule